// File: doc/BRIEF.md
# Indirectly Addressed General-Purpose I/O Bank

This block provides 22 general-purpose I/O pins split into three banks of uneven width. The banks are numbered 10-17, 20-25 and 30-37, and they are flattened as pad bits 0-7, 8-13 and 14-21. The host does not reach pin levels through one address per bank. It writes a bank number into an index port, then reads or writes the matching data port. The index/data pair can be moved to one of four places on the 8-bit host I/O bus, and a global select byte turns it on or off.

Each pin has its own configuration byte, written through a separate configuration path. The byte sets the pin's direction and its polarity, and it can hand the pad over to an alternate-function source. The configuration unlock logic and the alternate-function sources live outside this block. Here they appear as plain inputs: the select byte, the configuration write port, and the `altOut`/`altOe` vectors.

Host reads are registered. The read data and its valid flag appear one clock after the read strobe.

Top module: `gpio_idx_top`

## Requirements
- R1: Port pair placement. `selByte[7]` enables the index/data pair, and `selByte[1:0]` selects where it sits. The values 0, 1, 2 and 3 put the index port at 0xE0, 0xE2, 0xE4 and 0xEA. The data port is always the index address plus one.
- R2: While `selByte[7]` is 0, host reads and writes at any address have no effect, and `ioRdValid` stays 0.
- R3: A write to the index port stores the byte in full. A read of the index port returns the stored byte.
- R4: With the index at 0x01, 0x02 or 0x03, the data port reaches bank 10-17, 20-25 or 30-37, and data bit n is pin bank*10+n. With any other index, reads return 0x00 and writes change nothing.
- R5: With the index at 0x02, bits 7:6 of the data always read as 0.
- R6: Reset sets every pin to input with no inversion and no alternate function. It also clears every output latch and sets the index to 0x00. Every `padOe` bit is then 0.
- R7: Configuration bytes for pins 10-17 sit at 0xE0-0xE7, for pins 20-25 at 0xE8-0xED, and for pins 30-37 at 0xF5-0xFC. Within a byte, bit 0 is the direction (1 = input), bit 1 is the polarity (1 = inverted) and bit 3 selects the alternate function (1 = alternate). Writes to any other configuration address are ignored.
- R8: A normal output pin has `padOe` = 1 and `padOut` = latch XOR invert. A data read returns the latch value for that pin.
- R9: A normal input pin has `padOe` = 0 and `padOut` = 0. A data read returns `padIn` XOR invert for that pin. A data write leaves the pin's latch unchanged.
- R10: An alternate-function pin has `padOe` = `altOe` and `padOut` = `altOut` for that pin. A data read returns the raw `padIn` level, with no inversion.
- R11: `ioRdData` and `ioRdValid` are registered. They reflect a read strobe one clock later. When `ioRdValid` is 0, `ioRdData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| selByte | input | 8 | Global select byte: bit 7 enables the pair, bits 1:0 place it |
| ioAddr | input | 8 | Host I/O address |
| ioWrData | input | 8 | Host write data |
| ioWrEn | input | 1 | Host write strobe |
| ioRdEn | input | 1 | Host read strobe |
| ioRdData | output | 8 | Registered read data |
| ioRdValid | output | 1 | Read data is being driven |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrData | input | 8 | Configuration byte value |
| padIn | input | 22 | Pad input levels |
| altOut | input | 22 | Alternate-function output values |
| altOe | input | 22 | Alternate-function output enables |
| padOe | output | 22 | Pad output enables |
| padOut | output | 22 | Pad output values |

## Verification
The assertions assume that the host raises at most one of `ioWrEn` and `ioRdEn` in a cycle. They also assume that `selByte` only changes between accesses, so that a read strobe and the enable it depends on are seen in the same cycle.

The stimulus follows both rules. Every bus access lasts exactly one clock, driven and released on falling edges. The select byte and the pad inputs are changed only while no strobe is active.

Alternate-function enables are held all-ones, and later all-zeros, for whole phases. This lets the pad checks separate the alternate path from the latch path.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;

  // Strobes from the host-side decoder to the pin datapath
  typedef struct packed {
    logic       idxRd;     // read of the index port
    logic       dataRd;    // read of the data port
    logic       dataWr;    // write of the data port
    logic [1:0] bankCode;  // 0: no bank, 1..3: bank selected by index
    logic [7:0] idxVal;    // current index register
    logic [7:0] wrData;    // host write data
  } host_strobe_t;

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic cfgWe,
  input  logic cfgDir,
  input  logic cfgInv,
  input  logic cfgSpec,
  input  logic latchWe,
  input  logic latchD,
  input  logic padIn,
  input  logic altOut,
  input  logic altOe,
  output logic padOe,
  output logic padOut,
  output logic rdBit,
  output logic dirIn,
  output logic special,
  output logic latchQ
);

  logic invQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirIn   <= 1'b1;
      invQ    <= 1'b0;
      special <= 1'b0;
      latchQ  <= 1'b0;
    end else begin
      if (cfgWe) begin
        dirIn   <= cfgDir;
        invQ    <= cfgInv;
        special <= cfgSpec;
      end
      // an input pin keeps its latch
      if (latchWe && !dirIn) latchQ <= latchD;
    end
  end

  always_comb begin
    if (special) begin
      padOe  = altOe;
      padOut = altOut;
      rdBit  = padIn;
    end else if (dirIn) begin
      padOe  = 1'b0;
      padOut = 1'b0;
      rdBit  = padIn ^ invQ;
    end else begin
      padOe  = 1'b1;
      padOut = latchQ ^ invQ;
      rdBit  = latchQ;
    end
  end

endmodule

// File: rtl/gpio_idx_ctrl.sv
module gpio_idx_ctrl
  import gpio_idx_pkg::*;
#(
  parameter int ENABLE_BIT = 7,
  parameter int PORT_BASE0 = 'hE0,
  parameter int PORT_BASE1 = 'hE2,
  parameter int PORT_BASE2 = 'hE4,
  parameter int PORT_BASE3 = 'hEA,
  parameter int NUM_BANKS  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [7:0]   selByte,
  input  logic [7:0]   ioAddr,
  input  logic [7:0]   ioWrData,
  input  logic         ioWrEn,
  input  logic         ioRdEn,
  output host_strobe_t strb
);

  localparam logic [7:0] LAST_IDX = 8'(NUM_BANKS);

  logic [7:0] idxAddr;
  logic [7:0] dataAddr;
  logic       enabled;
  logic       hitIdx;
  logic       hitData;
  logic [7:0] idxReg;
  logic       unusedSelBits;

  assign unusedSelBits = ^selByte[6:2];

  always_comb begin
    case (selByte[1:0])
      2'd0:    idxAddr = 8'(PORT_BASE0);
      2'd1:    idxAddr = 8'(PORT_BASE1);
      2'd2:    idxAddr = 8'(PORT_BASE2);
      default: idxAddr = 8'(PORT_BASE3);
    endcase
  end

  assign dataAddr = idxAddr + 8'd1;
  assign enabled  = selByte[ENABLE_BIT];
  assign hitIdx   = enabled && (ioAddr == idxAddr);
  assign hitData  = enabled && (ioAddr == dataAddr);

  always_ff @(posedge clk) begin
    if (rst)                  idxReg <= 8'h00;
    else if (hitIdx && ioWrEn) idxReg <= ioWrData;
  end

  always_comb begin
    strb.idxRd    = hitIdx && ioRdEn;
    strb.dataRd   = hitData && ioRdEn;
    strb.dataWr   = hitData && ioWrEn;
    strb.idxVal   = idxReg;
    strb.wrData   = ioWrData;
    if (idxReg != 8'h00 && idxReg <= LAST_IDX) strb.bankCode = idxReg[1:0];
    else                                        strb.bankCode = 2'd0;
  end

  // R2: a disabled port pair cannot move the index
  a_r2_index_hold: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> (idxReg == $past(idxReg)));

endmodule

// File: rtl/gpio_idx_datapath.sv
module gpio_idx_datapath
  import gpio_idx_pkg::*;
#(
  parameter int BANK0_W     = 8,
  parameter int BANK1_W     = 6,
  parameter int BANK2_W     = 8,
  parameter int CFG_LO_BASE = 'hE0,
  parameter int CFG_HI_BASE = 'hF5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  host_strobe_t                          strb,
  input  logic                                  cfgWrEn,
  input  logic [7:0]                            cfgAddr,
  input  logic [7:0]                            cfgWrData,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0]    padIn,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0]    altOut,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0]    altOe,
  output logic [BANK0_W+BANK1_W+BANK2_W-1:0]    padOe,
  output logic [BANK0_W+BANK1_W+BANK2_W-1:0]    padOut,
  output logic [7:0]                            ioRdData,
  output logic                                  ioRdValid
);

  localparam int NUM_PINS = BANK0_W + BANK1_W + BANK2_W;

  function automatic int bankOf(int i);
    if (i < BANK0_W)           return 0;
    if (i < BANK0_W + BANK1_W) return 1;
    return 2;
  endfunction

  function automatic int bitOf(int i);
    if (i < BANK0_W)           return i;
    if (i < BANK0_W + BANK1_W) return i - BANK0_W;
    return i - BANK0_W - BANK1_W;
  endfunction

  function automatic int cfgOf(int i);
    if (bankOf(i) == 2) return CFG_HI_BASE + bitOf(i);
    return CFG_LO_BASE + i;
  endfunction

  logic [NUM_PINS-1:0] rdBit;
  logic [NUM_PINS-1:0] dirIn;
  logic [NUM_PINS-1:0] special;
  logic [NUM_PINS-1:0] latchQ;
  logic [7:0]          bankWord [3];
  logic [7:0]          rdValue;
  logic                unusedCfg;

  assign unusedCfg = cfgWrData[2] ^ (^cfgWrData[7:4]);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [1:0] BK_CODE = 2'(bankOf(i) + 1);
    localparam int         BT      = bitOf(i);
    localparam logic [7:0] CA      = 8'(cfgOf(i));

    gpio_pin_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .cfgWe   (cfgWrEn && (cfgAddr == CA)),
      .cfgDir  (cfgWrData[0]),
      .cfgInv  (cfgWrData[1]),
      .cfgSpec (cfgWrData[3]),
      .latchWe (strb.dataWr && (strb.bankCode == BK_CODE)),
      .latchD  (strb.wrData[BT]),
      .padIn   (padIn[i]),
      .altOut  (altOut[i]),
      .altOe   (altOe[i]),
      .padOe   (padOe[i]),
      .padOut  (padOut[i]),
      .rdBit   (rdBit[i]),
      .dirIn   (dirIn[i]),
      .special (special[i]),
      .latchQ  (latchQ[i])
    );
  end

  always_comb begin
    for (int b = 0; b < 3; b++) bankWord[b] = 8'h00;
    for (int i = 0; i < NUM_PINS; i++) bankWord[bankOf(i)][bitOf(i)] = rdBit[i];
  end

  always_comb begin
    if (strb.idxRd)                                rdValue = strb.idxVal;
    else if (strb.dataRd && strb.bankCode != 2'd0) rdValue = bankWord[strb.bankCode - 2'd1];
    else                                           rdValue = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ioRdValid <= 1'b0;
      ioRdData  <= 8'h00;
    end else begin
      ioRdValid <= strb.idxRd || strb.dataRd;
      ioRdData  <= (strb.idxRd || strb.dataRd) ? rdValue : 8'h00;
    end
  end

  // R9: data writes never reach the latch of an input pin
  a_r9_input_latch_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((latchQ ^ $past(latchQ)) & $past(dirIn)) == '0));

  // R8: only outputs or alternate pins may enable their pad
  a_r8_oe_needs_output: assert property (@(posedge clk) disable iff (rst)
    ((padOe & dirIn & ~special) == '0));

  // R5: the six-pin bank never reports its top two bits
  a_r5_bank1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.dataRd && strb.bankCode == 2'd2) |=> (ioRdData[7:6] == 2'b00));

  // R6: after reset no pad is driven
  a_r6_reset_no_drive: assert property (@(posedge clk)
    rst |=> (padOe == '0));

  // R11: idle read bus carries zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !ioRdValid |-> (ioRdData == 8'h00));

endmodule

// File: rtl/gpio_idx_top.sv
module gpio_idx_top
  import gpio_idx_pkg::*;
#(
  parameter int BANK0_W     = 8,
  parameter int BANK1_W     = 6,
  parameter int BANK2_W     = 8,
  parameter int CFG_LO_BASE = 'hE0,
  parameter int CFG_HI_BASE = 'hF5,
  parameter int ENABLE_BIT  = 7
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [7:0]                         selByte,
  input  logic [7:0]                         ioAddr,
  input  logic [7:0]                         ioWrData,
  input  logic                               ioWrEn,
  input  logic                               ioRdEn,
  output logic [7:0]                         ioRdData,
  output logic                               ioRdValid,
  input  logic                               cfgWrEn,
  input  logic [7:0]                         cfgAddr,
  input  logic [7:0]                         cfgWrData,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0] padIn,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0] altOut,
  input  logic [BANK0_W+BANK1_W+BANK2_W-1:0] altOe,
  output logic [BANK0_W+BANK1_W+BANK2_W-1:0] padOe,
  output logic [BANK0_W+BANK1_W+BANK2_W-1:0] padOut
);

  host_strobe_t strb;

  gpio_idx_ctrl #(
    .ENABLE_BIT (ENABLE_BIT),
    .NUM_BANKS  (3)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .selByte  (selByte),
    .ioAddr   (ioAddr),
    .ioWrData (ioWrData),
    .ioWrEn   (ioWrEn),
    .ioRdEn   (ioRdEn),
    .strb     (strb)
  );

  gpio_idx_datapath #(
    .BANK0_W     (BANK0_W),
    .BANK1_W     (BANK1_W),
    .BANK2_W     (BANK2_W),
    .CFG_LO_BASE (CFG_LO_BASE),
    .CFG_HI_BASE (CFG_HI_BASE)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .padIn     (padIn),
    .altOut    (altOut),
    .altOe     (altOe),
    .padOe     (padOe),
    .padOut    (padOut),
    .ioRdData  (ioRdData),
    .ioRdValid (ioRdValid)
  );

  // R2: disabled pair never answers a read
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !selByte[ENABLE_BIT] |=> !ioRdValid);

  // R11: valid only one clock after a read strobe
  a_r11_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    ioRdValid |-> $past(ioRdEn));

endmodule

// File: tb/gpio_idx_top_tb.sv
`timescale 1ns/1ps
module gpio_idx_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  selByte = 8'h00;
  logic [7:0]  ioAddr = 8'h00;
  logic [7:0]  ioWrData = 8'h00;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioRdData;
  logic        ioRdValid;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [21:0] padIn = {8'h5A, 6'h3C, 8'hA5};
  logic [21:0] altOut = '0;
  logic [21:0] altOe = '1;
  logic [21:0] padOe;
  logic [21:0] padOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_idx_top u_dut (
    .clk(clk), .rst(rst), .selByte(selByte), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioRdData(ioRdData), .ioRdValid(ioRdValid), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .padIn(padIn),
    .altOut(altOut), .altOe(altOe), .padOe(padOe), .padOut(padOut)
  );

  // op: 0 config write, 1 host write, 2 host read and compare
  // fields {op[1:0], addr[7:0], data[7:0], expected[7:0], requirement[7:0]}
  localparam int NV = 19;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'hE0, 8'h00, 8'h00, 8'd8},   // R8 pin10 output
    {2'd0, 8'hE1, 8'h02, 8'h00, 8'd8},   // R8 pin11 output inverted
    {2'd1, 8'hEA, 8'h01, 8'h00, 8'd3},   // R3 index = 1
    {2'd2, 8'hEA, 8'h00, 8'h01, 8'd3},   // R3 index readback
    {2'd1, 8'hEB, 8'hFF, 8'h00, 8'd9},   // R9 inputs ignore write
    {2'd2, 8'hEB, 8'h00, 8'hA7, 8'd8},   // R8 latches + input levels
    {2'd0, 8'hE2, 8'h03, 8'h00, 8'd9},   // R9 pin12 input inverted
    {2'd2, 8'hEB, 8'h00, 8'hA3, 8'd9},   // R9 inverted input read
    {2'd1, 8'hEA, 8'h02, 8'h00, 8'd5},   // R5 index = 2
    {2'd2, 8'hEB, 8'h00, 8'h3C, 8'd5},   // R5 upper bits zero
    {2'd0, 8'hEA, 8'h00, 8'h00, 8'd7},   // R7 pin22 output
    {2'd1, 8'hEB, 8'h00, 8'h00, 8'd8},
    {2'd2, 8'hEB, 8'h00, 8'h38, 8'd8},   // R8 pin22 latch 0
    {2'd1, 8'hEA, 8'h03, 8'h00, 8'd4},   // R4 index = 3
    {2'd0, 8'hF5, 8'h0A, 8'h00, 8'd10},  // R10 pin30 alternate + invert
    {2'd2, 8'hEB, 8'h00, 8'h5A, 8'd10},  // R10 raw level, no invert
    {2'd1, 8'hEA, 8'h05, 8'h00, 8'd4},   // R4 index out of range
    {2'd2, 8'hEB, 8'h00, 8'h00, 8'd4},   // R4 reads zero
    {2'd1, 8'hEB, 8'hFF, 8'h00, 8'd4}    // R4 write ignored
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [7:0] a, output logic [8:0] res);
    @(negedge clk);
    ioAddr = a; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    res = {ioRdValid, ioRdData};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run incomplete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    check("R6 padOe after reset", 32'(padOe), 32'h0);
    check("R6 padOut after reset", 32'(padOut), 32'h0);
    check("R11 no valid without read", 32'(ioRdValid), 32'h0);
    selByte = 8'h83;
    ioRead(8'hEA, r);
    check("R6 index resets to zero", 32'(r), 32'h100);
    ioRead(8'hEB, r);
    check("R4 index zero reads zero", 32'(r), 32'h100);

    for (int k = 0; k < NV; k++) begin
      logic [33:0] v;
      v = VEC[k];
      case (v[33:32])
        2'd0: cfgWrite(v[31:24], v[23:16]);
        2'd1: ioWrite(v[31:24], v[23:16]);
        default: begin
          ioRead(v[31:24], r);
          checks++;
          if (r !== {1'b1, v[15:8]}) begin
            errors++;
            $display("FAIL R%0d vector %0d actual %0h expected %0h", v[7:0], k, r, {1'b1, v[15:8]});
          end
        end
      endcase
    end

    // pads: pin10, pin11, pin22 outputs, pin30 alternate
    check("R8 pad enables", 32'(padOe), 32'h004403);
    check("R8 pad values", 32'(padOut), 32'h000001);
    @(negedge clk);
    altOut = 22'h004000;
    altOe  = '0;
    @(negedge clk);
    check("R10 alt value", 32'(padOut), 32'h004001);
    check("R10 alt enable", 32'(padOe), 32'h000403);

    // R9: pin12 latch untouched by writes made while it was input
    cfgWrite(8'hE2, 8'h00);
    check("R9 latch kept while input", 32'(padOut), 32'h004001);
    check("R9 pin12 now output", 32'(padOe), 32'h000407);

    // R7: unmapped config addresses ignored
    cfgWrite(8'hEE, 8'h00);
    cfgWrite(8'hF4, 8'h00);
    cfgWrite(8'hFD, 8'h00);
    check("R7 unmapped config ignored", 32'(padOe), 32'h000407);

    // R2: disabled pair
    selByte = 8'h03;
    ioWrite(8'hEA, 8'h01);
    ioRead(8'hEA, r);
    check("R2 disabled read silent", 32'(r), 32'h000);
    ioWrite(8'hEB, 8'h00);
    selByte = 8'h83;
    ioRead(8'hEA, r);
    check("R2 index unchanged", 32'(r), 32'h105);
    check("R2 latch unchanged", 32'(padOut), 32'h004001);

    // R1: port pair relocation
    selByte = 8'h80;
    ioRead(8'hE0, r);
    check("R1 sel0 index at E0", 32'(r), 32'h105);
    ioWrite(8'hE0, 8'h01);
    ioRead(8'hE1, r);
    check("R1 sel0 data at E1", 32'(r), 32'h1A3);
    @(negedge clk);
    check("R11 valid drops after one clock", 32'(ioRdValid), 32'h0);
    ioRead(8'hEA, r);
    check("R1 old pair inactive", 32'(r), 32'h000);
    selByte = 8'h81;
    ioRead(8'hE2, r);
    check("R1 sel1 index at E2", 32'(r), 32'h101);
    selByte = 8'h82;
    ioRead(8'hE4, r);
    check("R1 sel2 index at E4", 32'(r), 32'h101);
    ioRead(8'hE5, r);
    check("R1 sel2 data at E5", 32'(r), 32'h1A3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule